// File: doc/BRIEF.md
# Wide Free-Running System Timer with Consistent Split Reads

This block is a 64-bit up-counter that runs without stopping and is meant to give a whole chip one shared time base. Software cannot load or change the count. It sees the count through a small 32-bit register port. Six low windows return 32-bit slices of the count, each shifted four bits further up than the one before. A seventh window returns the upper 32 bits. The result is a set of 32-bit timers with coarser and coarser resolution.

Any read of a low window also stores the upper half of the count into a capture register, taken in the same cycle. A following read of that register then completes a 64-bit value whose two halves agree, even if a carry crossed the halfway point between the two reads.

Two compare channels each pick a slice of the count with a start position and a width, and compare it with a programmed value. When a match begins, the channel sends a one-cycle request pulse and sets a sticky flag. Counting can be paused by a suspend input or by a disable bit. A configuration bit chooses whether the application reset clears the timer or only the system reset does.

Top module: `wt_sys_timer`

## Requirements
- R1: On leaving reset the count equals the parameter INIT_COUNT (zero by default). From the first clock edge with reset released, it rises by one on every edge on which it is running.
- R2: Writes to addresses 0 to 7 (the seven windows and the capture register) change neither the count nor the capture register.
- R3: A read strobe at address k, for k from 0 to 5, returns count bits [31+4k:4k]. Address 6 returns count bits [63:32]. The value is taken from the count in the cycle the strobe is high and appears on rdata_o from the following cycle. rdata_o holds its value when no read is made.
- R4: A read of address 0 to 5 loads count bits [63:32] of that same cycle into the capture register. The capture register reads at address 7, resets to zero, and keeps its value when address 6 or 7 is read.
- R5: Compare channel n has a value register at address 8+n and a control register at address 10+n. The control register holds the start position in bits [4:0], the width minus one in bits [12:8] and the enable in bit 16, and all other control bits read as zero. The channel matches when it is enabled and the slice of the count that starts at the start position, with the given width, equals the same number of low bits of the value register.
- R6: On the first cycle of a match, irq_o[n] is high for exactly one cycle, one clock after the count that matched. In the same cycle, bit n of the flag register at address 12 becomes 1 and stays 1. Writing 1 to that bit clears it. If a new match sets the flag in the same cycle as the clear, the flag stays 1.
- R7: While suspend_i is high, the count holds its value, and all registers can still be read.
- R8: Bit 0 of the configuration register at address 13 is a disable bit. While it is 1, the count holds.
- R9: Bit 1 of address 13 is a keep bit. When it is 0, a low app_rst_n clears the count (to INIT_COUNT), the capture, compare, control and flag registers, and the disable bit. When it is 1, a low app_rst_n has no effect. A low sys_rst_n clears everything, the keep bit included.
- R10: After all ones, the count becomes zero with no flag or side effect. A compare that matches the zero count is detected in the cycle after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| sys_rst_n | input | 1 | System reset, active low, synchronous; clears everything |
| app_rst_n | input | 1 | Application reset, active low, synchronous; obeys the keep bit |
| suspend_i | input | 1 | Pauses counting while high |
| rd_en_i | input | 1 | Read strobe for one cycle |
| wr_en_i | input | 1 | Write strobe for one cycle |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | WIN_W | Write data |
| rdata_o | output | WIN_W | Read data, registered, valid the cycle after the strobe |
| irq_o | output | NUM_CMP | One-cycle compare request pulses, one per channel |

## Verification
The bench builds the timer with its default widths, but with INIT_COUNT set to 64'hFFFF_FFFF_FFFF_FE00. This setting moves the carry out of the low half and the full 64-bit wrap to about 512 cycles after each reset. The halves-consistency of the capture, the change of the upper window across the carry, and a full-width compare on the zero count just after the wrap all then fall inside a short run. Each application reset reloads the same start value, so the wrap occurs again under a mix of random reads, suspends and register writes. A behavioural model follows every clock and predicts rdata_o and irq_o.

// File: rtl/wt_pkg.sv
package wt_pkg;

   // Control register field positions of one compare channel
   localparam int CTL_START_LSB = 0;
   localparam int CTL_WM1_LSB   = 8;
   localparam int CTL_EN_BIT    = 16;
   localparam int CTL_FLD_W     = 5;

   // Configuration register bit positions
   localparam int CFG_DIS_BIT   = 0;
   localparam int CFG_KEEP_BIT  = 1;

   typedef struct packed {
      logic                 en;
      logic [CTL_FLD_W-1:0] wm1;
      logic [CTL_FLD_W-1:0] start;
   } cmp_ctl_t;

endpackage

// File: rtl/wt_counter.sv
module wt_counter #(
   parameter int               CNT_W      = 64,
   parameter logic [CNT_W-1:0] INIT_COUNT = '0
) (
   input  logic             clk,
   input  logic             clear_i,
   input  logic             run_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ONES = '1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (clear_i)
         cnt_q <= INIT_COUNT;
      else if (run_i)
         cnt_q <= cnt_q + ONE;
   end

   assign cnt_o = cnt_q;

   // R1: a running cycle advances the count by exactly one
   p_count_step_r1: assert property (@(posedge clk) disable iff (clear_i)
      (run_i && !clear_i) |=> cnt_q == $past(cnt_q) + ONE);

   // R7 / R8: a paused cycle leaves the count alone
   p_count_hold_r7: assert property (@(posedge clk) disable iff (clear_i)
      (!run_i && !clear_i) |=> $stable(cnt_q));

   // R10: all ones rolls to zero
   p_count_wrap_r10: assert property (@(posedge clk) disable iff (clear_i)
      (run_i && !clear_i && cnt_q == ONES) |=> cnt_q == '0);

endmodule

// File: rtl/wt_window.sv
module wt_window #(
   parameter int CNT_W    = 64,
   parameter int WIN_W    = 32,
   parameter int WIN_STEP = 4,
   parameter int NUM_LOW  = 6,
   parameter int ADDR_W   = 4
) (
   input  logic              clk,
   input  logic              clear_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic [WIN_W-1:0]  win_o,
   output logic [WIN_W-1:0]  cap_o
);

   localparam int HI_LSB  = CNT_W - WIN_W;
   localparam int A_HIGH  = NUM_LOW;
   localparam int A_CAPT  = NUM_LOW + 1;
   localparam int TOP_LOW = WIN_STEP * (NUM_LOW - 1) + WIN_W;

   if (TOP_LOW > CNT_W) begin : g_bad_span
      $error("wt_window: low windows reach past the counter");
   end

   logic [WIN_W-1:0] low_win [NUM_LOW];
   logic [WIN_W-1:0] high_win;
   logic [WIN_W-1:0] cap_q;
   logic             rd_low;

   for (genvar k = 0; k < NUM_LOW; k++) begin : g_low
      assign low_win[k] = cnt_i[WIN_STEP*k +: WIN_W];
   end
   assign high_win = cnt_i[HI_LSB +: WIN_W];

   assign rd_low = rd_i && (int'(addr_i) < NUM_LOW);

   always_ff @(posedge clk) begin
      if (clear_i)
         cap_q <= '0;
      else if (rd_low)
         cap_q <= high_win;
   end

   always_comb begin
      win_o = '0;
      for (int k = 0; k < NUM_LOW; k++)
         if (int'(addr_i) == k) win_o = low_win[k];
      if (int'(addr_i) == A_HIGH) win_o = high_win;
      if (int'(addr_i) == A_CAPT) win_o = cap_q;
   end

   assign cap_o = cap_q;

   // R4: capture takes the upper half seen in the reading cycle
   p_cap_load_r4: assert property (@(posedge clk) disable iff (clear_i)
      (rd_low && !clear_i) |=> cap_q == $past(cnt_i[CNT_W-1:HI_LSB]));

   // R4: no low-window read, no capture change
   p_cap_hold_r4: assert property (@(posedge clk) disable iff (clear_i)
      (!rd_low && !clear_i) |=> $stable(cap_q));

endmodule

// File: rtl/wt_compare.sv
module wt_compare
   import wt_pkg::*;
#(
   parameter int CNT_W = 64,
   parameter int WIN_W = 32
) (
   input  logic             clk,
   input  logic             clear_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [WIN_W-1:0] cmp_i,
   input  cmp_ctl_t         ctl_i,
   input  logic             flag_clr_i,
   output logic             pulse_o,
   output logic             flag_o
);

   logic [WIN_W-1:0] slice;
   logic [WIN_W-1:0] mask;
   logic             hit;
   logic             hit_q;
   logic             pulse_q;
   logic             flag_q;

   assign slice = WIN_W'(cnt_i >> ctl_i.start);

   always_comb begin
      for (int i = 0; i < WIN_W; i++)
         mask[i] = (i <= int'(ctl_i.wm1));
   end

   assign hit = ctl_i.en && ((slice & mask) == (cmp_i & mask));

   always_ff @(posedge clk) begin
      if (clear_i) begin
         hit_q   <= 1'b0;
         pulse_q <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         hit_q   <= hit;
         pulse_q <= hit && !hit_q;
         flag_q  <= (flag_q && !flag_clr_i) || (hit && !hit_q);
      end
   end

   assign pulse_o = pulse_q;
   assign flag_o  = flag_q;

   // R6: a request is never longer than one cycle
   p_pulse_single_r6: assert property (@(posedge clk) disable iff (clear_i)
      pulse_q |=> !pulse_q);

   // R6: every request is recorded in the flag
   p_pulse_flags_r6: assert property (@(posedge clk) disable iff (clear_i)
      pulse_q |-> flag_q);

   // R6: flag only drops on a clear write
   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (clear_i)
      (flag_q && !flag_clr_i && !clear_i) |=> flag_q);

endmodule

// File: rtl/wt_sys_timer.sv
module wt_sys_timer
   import wt_pkg::*;
#(
   parameter int               CNT_W      = 64,
   parameter int               WIN_W      = 32,
   parameter int               WIN_STEP   = 4,
   parameter int               NUM_LOW    = 6,
   parameter int               NUM_CMP    = 2,
   parameter int               ADDR_W     = 4,
   parameter logic [CNT_W-1:0] INIT_COUNT = '0
) (
   input  logic               clk,
   input  logic               sys_rst_n,
   input  logic               app_rst_n,
   input  logic               suspend_i,
   input  logic               rd_en_i,
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [WIN_W-1:0]   wdata_i,
   output logic [WIN_W-1:0]   rdata_o,
   output logic [NUM_CMP-1:0] irq_o
);

   localparam int A_CAPT  = NUM_LOW + 1;
   localparam int A_CMPV  = NUM_LOW + 2;
   localparam int A_CTL   = A_CMPV + NUM_CMP;
   localparam int A_FLG   = A_CTL + NUM_CMP;
   localparam int A_CFG   = A_FLG + 1;
   localparam int N_ADDR  = A_CFG + 1;

   if (N_ADDR > (1 << ADDR_W)) begin : g_bad_addr
      $error("wt_sys_timer: address space too small");
   end
   if (WIN_W < CTL_EN_BIT + 1 || WIN_W > 32 || WIN_W > CNT_W) begin : g_bad_win
      $error("wt_sys_timer: window width out of range");
   end
   if (NUM_CMP < 1 || NUM_CMP > WIN_W) begin : g_bad_cmp
      $error("wt_sys_timer: compare count out of range");
   end

   logic                 keep_q;
   logic                 dis_q;
   logic                 tmr_clr;
   logic                 run;
   logic [CNT_W-1:0]     cnt;
   logic [WIN_W-1:0]     win_val;
   logic [WIN_W-1:0]     cap_val;
   logic [WIN_W-1:0]     rd_mux;
   logic [WIN_W-1:0]     rdata_q;
   logic [WIN_W-1:0]     cmp_q   [NUM_CMP];
   cmp_ctl_t             ctl_q   [NUM_CMP];
   logic [NUM_CMP-1:0]   flag;
   logic [NUM_CMP-1:0]   pulse;
   logic [NUM_CMP-1:0]   flag_clr;
   logic                 wr_cfg;
   logic                 wr_flg;

   assign wr_cfg  = wr_en_i && (addr_i == ADDR_W'(A_CFG));
   assign wr_flg  = wr_en_i && (addr_i == ADDR_W'(A_FLG));

   // Reset selection: keep bit lives only under system reset
   always_ff @(posedge clk) begin
      if (!sys_rst_n)
         keep_q <= 1'b0;
      else if (wr_cfg)
         keep_q <= wdata_i[CFG_KEEP_BIT];
   end

   assign tmr_clr = !sys_rst_n || (!app_rst_n && !keep_q);

   always_ff @(posedge clk) begin
      if (tmr_clr)
         dis_q <= 1'b0;
      else if (wr_cfg)
         dis_q <= wdata_i[CFG_DIS_BIT];
   end

   assign run = !dis_q && !suspend_i;

   wt_counter #(
      .CNT_W      (CNT_W),
      .INIT_COUNT (INIT_COUNT)
   ) u_counter (
      .clk     (clk),
      .clear_i (tmr_clr),
      .run_i   (run),
      .cnt_o   (cnt)
   );

   wt_window #(
      .CNT_W    (CNT_W),
      .WIN_W    (WIN_W),
      .WIN_STEP (WIN_STEP),
      .NUM_LOW  (NUM_LOW),
      .ADDR_W   (ADDR_W)
   ) u_window (
      .clk     (clk),
      .clear_i (tmr_clr),
      .rd_i    (rd_en_i),
      .addr_i  (addr_i),
      .cnt_i   (cnt),
      .win_o   (win_val),
      .cap_o   (cap_val)
   );

   for (genvar n = 0; n < NUM_CMP; n++) begin : g_chan
      always_ff @(posedge clk) begin
         if (tmr_clr) begin
            cmp_q[n] <= '0;
            ctl_q[n] <= '0;
         end else if (wr_en_i) begin
            if (addr_i == ADDR_W'(A_CMPV + n))
               cmp_q[n] <= wdata_i;
            if (addr_i == ADDR_W'(A_CTL + n)) begin
               ctl_q[n].start <= wdata_i[CTL_START_LSB +: CTL_FLD_W];
               ctl_q[n].wm1   <= wdata_i[CTL_WM1_LSB +: CTL_FLD_W];
               ctl_q[n].en    <= wdata_i[CTL_EN_BIT];
            end
         end
      end

      assign flag_clr[n] = wr_flg && wdata_i[n];

      wt_compare #(
         .CNT_W (CNT_W),
         .WIN_W (WIN_W)
      ) u_cmp (
         .clk        (clk),
         .clear_i    (tmr_clr),
         .cnt_i      (cnt),
         .cmp_i      (cmp_q[n]),
         .ctl_i      (ctl_q[n]),
         .flag_clr_i (flag_clr[n]),
         .pulse_o    (pulse[n]),
         .flag_o     (flag[n])
      );
   end

   always_comb begin
      rd_mux = '0;
      if (int'(addr_i) <= A_CAPT)
         rd_mux = win_val;
      for (int n = 0; n < NUM_CMP; n++) begin
         if (int'(addr_i) == A_CMPV + n)
            rd_mux = cmp_q[n];
         if (int'(addr_i) == A_CTL + n) begin
            rd_mux[CTL_START_LSB +: CTL_FLD_W] = ctl_q[n].start;
            rd_mux[CTL_WM1_LSB +: CTL_FLD_W]   = ctl_q[n].wm1;
            rd_mux[CTL_EN_BIT]                 = ctl_q[n].en;
         end
      end
      if (int'(addr_i) == A_FLG)
         rd_mux[NUM_CMP-1:0] = flag;
      if (int'(addr_i) == A_CFG) begin
         rd_mux[CFG_DIS_BIT]  = dis_q;
         rd_mux[CFG_KEEP_BIT] = keep_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!sys_rst_n)
         rdata_q <= '0;
      else if (rd_en_i)
         rdata_q <= rd_mux;
   end

   assign rdata_o = rdata_q;
   assign irq_o   = pulse;

   // R9: with the keep bit clear, application reset reloads the count
   p_app_clears_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (!app_rst_n && !keep_q) |=> cnt == INIT_COUNT);

   // R9: with the keep bit set, application reset does not stop counting
   p_app_ignored_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (!app_rst_n && keep_q && !dis_q && !suspend_i)
         |=> cnt == $past(cnt) + CNT_W'(1));

   // R3: read data only moves after a read strobe
   p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
      !rd_en_i |=> $stable(rdata_o));

   // R2: window and capture writes leave the capture alone
   p_wr_ignored_r2: assert property (@(posedge clk) disable iff (tmr_clr)
      (wr_en_i && !rd_en_i && int'(addr_i) <= A_CAPT && !tmr_clr) |=> $stable(cap_val));

endmodule

// File: tb/wt_sys_timer_bench.sv
`timescale 1ns/1ps
module wt_sys_timer_bench;

   localparam logic [63:0] INIT = 64'hFFFF_FFFF_FFFF_FE00;

   logic        clk = 1'b0;
   logic        sys_n = 1'b0;
   logic        app_n = 1'b1;
   logic        susp = 1'b0;
   logic        rd = 1'b0;
   logic        wr = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [1:0]  irq;

   always #2.5 clk = ~clk;

   wt_sys_timer #(.INIT_COUNT(INIT)) u_wt_sys_timer (
      .clk       (clk),
      .sys_rst_n (sys_n),
      .app_rst_n (app_n),
      .suspend_i (susp),
      .rd_en_i   (rd),
      .wr_en_i   (wr),
      .addr_i    (addr),
      .wdata_i   (wdata),
      .rdata_o   (rdata),
      .irq_o     (irq)
   );

   // Behavioural reference state
   logic [63:0] m_cnt;
   logic [31:0] m_cap, m_rdata;
   logic [31:0] m_cmp [2];
   logic [31:0] m_ctl [2];
   logic [1:0]  m_flag, m_hitq, m_pulse;
   logic        m_dis, m_keep;

   int    vecs = 0;
   int    errs = 0;
   int    last_rd = 0;
   string phase = "R1";
   int    pulses_seen = 0;

   function automatic logic [31:0] read_val(int a);
      logic [31:0] v;
      v = '0;
      if (a < 6)        v = m_cnt[4*a +: 32];
      else if (a == 6)  v = m_cnt[63:32];
      else if (a == 7)  v = m_cap;
      else if (a < 10)  v = m_cmp[a-8];
      else if (a < 12)  v = m_ctl[a-10];
      else if (a == 12) v = {30'd0, m_flag};
      else if (a == 13) v = {30'd0, m_keep, m_dis};
      return v;
   endfunction

   function automatic logic chan_hit(int n);
      logic [31:0] sl, mk;
      int w;
      w  = int'(m_ctl[n][12:8]);
      mk = (w >= 31) ? 32'hFFFF_FFFF : ((32'h1 << (w + 1)) - 32'h1);
      sl = 32'(m_cnt >> m_ctl[n][4:0]);
      return m_ctl[n][16] && ((sl & mk) == (m_cmp[n] & mk));
   endfunction

   function automatic string tag_of(int a);
      if (a <= 6)  return "R3";
      if (a == 7)  return "R4";
      if (a < 12)  return "R5";
      if (a == 12) return "R6";
      return "R9";
   endfunction

   task automatic step();
      logic [63:0] n_cnt;
      logic [31:0] n_cap, n_rdata;
      logic [31:0] n_cmp [2];
      logic [31:0] n_ctl [2];
      logic [1:0]  n_flag, n_hitq, n_pulse, hv, clr;
      logic        n_dis, n_keep, tclr;
      int          a;
      a = int'(addr);
      for (int n = 0; n < 2; n++) hv[n] = chan_hit(n);
      tclr    = !sys_n || (!app_n && !m_keep);
      n_keep  = !sys_n ? 1'b0 : ((wr && a == 13) ? wdata[1] : m_keep);
      n_rdata = !sys_n ? 32'd0 : (rd ? read_val(a) : m_rdata);
      if (tclr) begin
         n_cnt = INIT; n_cap = '0; n_dis = 1'b0;
         n_cmp[0] = '0; n_cmp[1] = '0; n_ctl[0] = '0; n_ctl[1] = '0;
         n_flag = '0; n_hitq = '0; n_pulse = '0;
      end else begin
         n_cnt = m_cnt + ((!m_dis && !susp) ? 64'd1 : 64'd0);
         n_cap = (rd && a < 6) ? m_cnt[63:32] : m_cap;
         n_dis = (wr && a == 13) ? wdata[0] : m_dis;
         for (int n = 0; n < 2; n++) begin
            n_cmp[n] = (wr && a == 8 + n) ? wdata : m_cmp[n];
            n_ctl[n] = (wr && a == 10 + n) ? (wdata & 32'h0001_1F1F) : m_ctl[n];
         end
         clr     = (wr && a == 12) ? wdata[1:0] : 2'b00;
         n_pulse = hv & ~m_hitq;
         n_hitq  = hv;
         n_flag  = (m_flag & ~clr) | n_pulse;
      end
      if (rd) last_rd = a;
      @(posedge clk);
      #1;
      m_cnt = n_cnt; m_cap = n_cap; m_rdata = n_rdata; m_dis = n_dis; m_keep = n_keep;
      m_cmp[0] = n_cmp[0]; m_cmp[1] = n_cmp[1]; m_ctl[0] = n_ctl[0]; m_ctl[1] = n_ctl[1];
      m_flag = n_flag; m_hitq = n_hitq; m_pulse = n_pulse;
      vecs++;
      if (rdata !== m_rdata) begin
         errs++;
         $display("FAIL %s [%s] rdata addr %0d: actual %h expected %h",
                  tag_of(last_rd), phase, last_rd, rdata, m_rdata);
      end
      vecs++;
      if (irq !== m_pulse) begin
         errs++;
         $display("FAIL R6 [%s] irq: actual %b expected %b", phase, irq, m_pulse);
      end
      if (irq[0]) pulses_seen++;
      rd = 1'b0; wr = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic rd_op(int a);
      rd = 1'b1; addr = 4'(a); step();
   endtask

   task automatic wr_op(int a, logic [31:0] d);
      wr = 1'b1; addr = 4'(a); wdata = d; step();
   endtask

   initial begin
      #(5.0 * 200000);
      errs++;
      $display("FAIL R1 watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      m_cnt = '0; m_cap = '0; m_rdata = '0; m_dis = 0; m_keep = 0;
      m_cmp[0] = '0; m_cmp[1] = '0; m_ctl[0] = '0; m_ctl[1] = '0;
      m_flag = '0; m_hitq = '0; m_pulse = '0;
      // R1: reset state and first counting cycles
      phase = "R1";
      idle(3);
      sys_n = 1'b1;
      rd_op(0); rd_op(7); rd_op(6); idle(2);
      // R3 / R4: every window, capture behaviour
      phase = "R3";
      for (int a = 0; a < 14; a++) rd_op(a);
      phase = "R4";
      rd_op(2); rd_op(6); rd_op(7); rd_op(7); rd_op(5); rd_op(7);
      // R2: writes to windows and capture ignored
      phase = "R2";
      for (int a = 0; a < 8; a++) wr_op(a, 32'hA5A5_0000 + 32'(a));
      rd_op(7); rd_op(0); rd_op(6);
      // R7: suspend holds the count, reads still work
      phase = "R7";
      susp = 1'b1;
      rd_op(0); idle(5); rd_op(1); rd_op(7);
      susp = 1'b0;
      rd_op(0);
      // R8: disable bit
      phase = "R8";
      wr_op(13, 32'h1); rd_op(13); idle(6); rd_op(0);
      wr_op(13, 32'h0); rd_op(0);
      // R5 / R6 / R10: compares across the wrap
      phase = "R5";
      wr_op(8, 32'h0);
      wr_op(10, 32'hFFFF_FF00 | 32'h0001_1F00);   // full 32 bits from bit 0, junk bits dropped
      wr_op(9, 32'h5);
      wr_op(11, 32'h0001_0304);                   // 4 bits starting at bit 4
      rd_op(10); rd_op(11);
      phase = "R10";
      for (int i = 0; i < 70; i++) begin
         idle(6); rd_op(0); rd_op(7); rd_op(12);
      end
      phase = "R6";
      wr_op(12, 32'h3); rd_op(12);
      idle(40); rd_op(12); wr_op(12, 32'h2); rd_op(12);
      // R9: application reset with keep clear then set
      phase = "R9";
      app_n = 1'b0; idle(2); app_n = 1'b1;
      rd_op(0); rd_op(10); rd_op(13);
      wr_op(8, 32'h0); wr_op(10, 32'h0001_1F00);
      wr_op(13, 32'h2); rd_op(13);
      app_n = 1'b0; idle(3); rd_op(0); app_n = 1'b1;
      rd_op(10); rd_op(13);
      // random mix, including app resets under both keep settings
      phase = "R9";
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         susp  = (r < 8);
         app_n = !(r == 50);
         if (r < 60) begin
            rd = 1'b1; addr = 4'($urandom_range(0, 13));
         end else if (r < 64) begin
            wr = 1'b1; addr = 4'($urandom_range(0, 13));
            wdata = $urandom();
            if (addr == 4'd13) wdata[0] = 1'b0;
         end
         step();
      end
      susp = 1'b0; app_n = 1'b1;
      phase = "R9";
      sys_n = 1'b0; idle(2); sys_n = 1'b1;
      rd_op(13); rd_op(7);
      vecs++;
      if (pulses_seen == 0) begin
         errs++;
         $display("FAIL R10 wrap compare: actual %0d pulses expected >0", pulses_seen);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule